// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a two-part logical address into a flat 32-bit linear address. The first part is a 16-bit selector and the second is a 32-bit offset. A field in the selector picks one of two descriptor tables: a global table shared by all code, or a local table that belongs to the current context. A second field picks an entry in that table, and a third carries the privilege level of the requester. The chosen descriptor holds a base, a limit, a descriptor privilege level, a present flag and three permission bits.

On each request the block checks the entry in this order: present flag, offset against limit, requested level against descriptor level, and finally the access kind against the permission bits. It returns either the sum of base and offset or a single fault code, one cycle after the request.

Software or a sequencer fills both tables through a single write port, one entry per cycle. Reset marks every entry of both tables as not present.

Top module: `segx_xlate_unit`

## Requirements
- R1: The selector fields are decoded as follows. Bits [15:3] are the entry index. Bit 2 chooses the table: 0 is the global table and 1 is the local table. Bits [1:0] are the requested privilege level.
- R2: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` high on the following clock edge. A cycle without a request produces no response.
- R3: With no fault, `rsp_lin` equals the descriptor base plus the offset, modulo 2^32. With any fault, `rsp_lin` is 0.
- R4: The fault code is 1 (absent) when the entry's present flag is clear, or when the index is at or beyond the table depth (default 32 entries per table). This fault takes precedence over every other check.
- R5: The fault code is 2 (limit) when the offset is strictly greater than the descriptor limit. An offset equal to the limit is accepted.
- R6: The fault code is 3 (privilege) when the requested level is numerically greater than the descriptor level. Level 0 is the most privileged.
- R7: The fault code is 4 (access kind) when the permission bit for the requested kind is clear. The permission bits are: bit 0 read, bit 1 write, bit 2 execute. The kind encoding is 0 read, 1 write, 2 execute. Kind 3 is always refused with code 4.
- R8: When several checks fail on a present entry, limit is reported before privilege, and privilege before access kind. Code 0 means no fault.
- R9: A write updates only the entry named by its table bit and index. Entries with the same index in the other table are unchanged. The write is visible to requests in later cycles.
- R10: After reset, `rsp_valid` is low and every entry of both tables is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one descriptor this cycle |
| wr_ti | input | 1 | Table for the write: 0 global, 1 local |
| wr_idx | input | TBL_AW | Entry index for the write |
| wr_base | input | 32 | Segment base address |
| wr_limit | input | 32 | Last valid offset of the segment |
| wr_dpl | input | 2 | Descriptor privilege level |
| wr_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| wr_present | input | 1 | Present flag |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 16 | Selector: index, table bit, requested level |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_lin | output | 32 | Linear address, or 0 on a fault |
| rsp_fault | output | 3 | Fault code: 0 none, 1 absent, 2 limit, 3 privilege, 4 access kind |

## Verification
The hardest cases to reach from the ports are the ones where several checks fail at once. Only there does the fault ordering show. They need a descriptor whose limit, level and permissions are all chosen so that a single request breaks all three checks together. The stimulus loads such a local entry and issues one request against it that is past the limit, from too weak a level, and of a kind the entry forbids. A second case tests aliasing. An entry is written at an index whose low bits match an out-of-range selector index. The test then confirms that the out-of-range request still reports absent rather than reaching that entry.

// File: rtl/segx_pkg.sv
package segx_pkg;

    localparam int SEL_W  = 16;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 13;
    localparam int NUM_TBL = 2;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_LIMIT  = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_KIND   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_BAD = 2'd3
    } acc_e;

    // Selector layout; the field order is decoded by this block.
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             ti;
        logic [1:0]       rpl;
    } sel_t;

    typedef struct packed {
        logic              present;
        logic [1:0]        dpl;
        logic [2:0]        perm;   // [0] read, [1] write, [2] execute
        logic [ADDR_W-1:0] limit;
        logic [ADDR_W-1:0] base;
    } desc_t;

    function automatic logic kind_allowed(logic [2:0] perm, acc_e kind);
        case (kind)
            ACC_RD:  return perm[0];
            ACC_WR:  return perm[1];
            ACC_EX:  return perm[2];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/segx_desc_table.sv
module segx_desc_table
    import segx_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  desc_t            wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);

    localparam int DEPTH = 1 << AW;

    desc_t ent_q [DEPTH];
    logic  in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i].present <= 1'b0;
            end
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_desc;
        end
    end

    generate
        if (AW < IDX_W) begin : g_narrow
            assign in_range = (rd_idx[IDX_W-1:AW] == '0);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        rd_desc         = ent_q[rd_idx[AW-1:0]];
        rd_desc.present = ent_q[rd_idx[AW-1:0]].present & in_range;
    end

    // A write lands in the addressed entry (R9)
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_desc)));

endmodule

// File: rtl/segx_rule_check.sv
module segx_rule_check
    import segx_pkg::*;
(
    input  desc_t             desc,
    input  logic [ADDR_W-1:0] off,
    input  logic [1:0]        rpl,
    input  acc_e              kind,
    output fault_e            fault
);

    logic over_limit;
    logic weak_level;
    logic kind_ok;

    assign over_limit = off > desc.limit;
    assign weak_level = rpl > desc.dpl;
    assign kind_ok    = kind_allowed(desc.perm, kind);

    // Fixed priority: absent, limit, privilege, access kind.
    always_comb begin
        if (!desc.present)   fault = FLT_ABSENT;
        else if (over_limit) fault = FLT_LIMIT;
        else if (weak_level) fault = FLT_PRIV;
        else if (!kind_ok)   fault = FLT_KIND;
        else                 fault = FLT_NONE;
    end

endmodule

// File: rtl/segx_xlate_unit.sv
module segx_xlate_unit
    import segx_pkg::*;
#(
    parameter int TBL_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ti,
    input  logic [TBL_AW-1:0] wr_idx,
    input  logic [31:0]       wr_base,
    input  logic [31:0]       wr_limit,
    input  logic [1:0]        wr_dpl,
    input  logic [2:0]        wr_perm,
    input  logic              wr_present,
    input  logic              req_valid,
    input  logic [15:0]       req_sel,
    input  logic [31:0]       req_off,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic [31:0]       rsp_lin,
    output logic [2:0]        rsp_fault
);

    sel_t   sel;
    desc_t  wr_desc;
    desc_t  rd_all [NUM_TBL];
    desc_t  cur;
    fault_e fault_nx;
    fault_e fault_q;
    logic   valid_q;
    logic [ADDR_W-1:0] lin_q;

    assign sel     = sel_t'(req_sel);
    assign wr_desc = '{present: wr_present, dpl: wr_dpl, perm: wr_perm,
                       limit: wr_limit, base: wr_base};

    generate
        for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
            segx_desc_table #(.AW(TBL_AW)) u_tbl (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en && (wr_ti == 1'(t))),
                .wr_idx  (wr_idx),
                .wr_desc (wr_desc),
                .rd_idx  (sel.idx),
                .rd_desc (rd_all[t])
            );
        end
    endgenerate

    assign cur = rd_all[sel.ti];

    segx_rule_check u_rules (
        .desc  (cur),
        .off   (req_off),
        .rpl   (sel.rpl),
        .kind  (acc_e'(req_kind)),
        .fault (fault_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            fault_q <= FLT_NONE;
            lin_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                fault_q <= fault_nx;
                lin_q   <= (fault_nx == FLT_NONE) ? cur.base + req_off : '0;
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_lin   = lin_q;
    assign rsp_fault = fault_q;

    // One response per request, one cycle later (R2)
    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // Absent entries win over every other check (R4)
    assert_absent_first_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cur.present) |=> (rsp_fault == FLT_ABSENT));

    // Offset past limit on a present entry reports limit (R5, R8)
    assert_limit_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur.present && (req_off > cur.limit)) |=> (rsp_fault == FLT_LIMIT));

    // Level too weak within limit reports privilege (R6, R8)
    assert_priv_fault_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur.present && (req_off <= cur.limit) && (sel.rpl > cur.dpl))
        |=> (rsp_fault == FLT_PRIV));

    // A clean result lies at base plus offset (R3)
    assert_lin_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (fault_nx == FLT_NONE)) |=> (rsp_lin - $past(req_off) == $past(cur.base)));

endmodule

// File: tb/segx_xlate_unit_bench.sv
module segx_xlate_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_ti, wr_present;
    logic [4:0]  wr_idx;
    logic [31:0] wr_base, wr_limit;
    logic [1:0]  wr_dpl;
    logic [2:0]  wr_perm;
    logic        req_valid;
    logic [15:0] req_sel;
    logic [31:0] req_off;
    logic [1:0]  req_kind;
    logic        rsp_valid;
    logic [31:0] rsp_lin;
    logic [2:0]  rsp_fault;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    segx_xlate_unit u_segx_xlate_unit (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_ti(wr_ti), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_dpl(wr_dpl), .wr_perm(wr_perm), .wr_present(wr_present),
        .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_lin(rsp_lin), .rsp_fault(rsp_fault)
    );

    // {sel[16], off[32], kind[2], fault[3], lin[32]}
    localparam int NV = 17;
    localparam logic [84:0] VEC [NV] = '{
        {16'h000B, 32'h0000_1234, 2'd0, 3'd0, 32'h1000_1234},
        {16'h0008, 32'h0000_FFFF, 2'd1, 3'd0, 32'h1000_FFFF},
        {16'h0008, 32'h0001_0000, 2'd0, 3'd2, 32'h0},
        {16'h0008, 32'h0000_0000, 2'd2, 3'd4, 32'h0},
        {16'h0008, 32'h0000_0000, 2'd3, 3'd4, 32'h0},
        {16'h0010, 32'h0000_2000, 2'd2, 3'd0, 32'h0000_1000},
        {16'h0011, 32'h0000_2000, 2'd2, 3'd3, 32'h0},
        {16'h0011, 32'h0000_0000, 2'd0, 3'd3, 32'h0},
        {16'h0018, 32'h0000_0000, 2'd0, 3'd1, 32'h0},
        {16'h000C, 32'h0000_0FFF, 2'd0, 3'd0, 32'h0040_0FFF},
        {16'h000F, 32'h0000_1000, 2'd1, 3'd2, 32'h0},
        {16'h000E, 32'h0000_0000, 2'd1, 3'd4, 32'h0},
        {16'h0015, 32'h0000_0010, 2'd1, 3'd0, 32'hABCD_0010},
        {16'h0000, 32'h0000_0000, 2'd0, 3'd1, 32'h0},
        {16'h0140, 32'h0000_0000, 2'd0, 3'd1, 32'h0},
        {16'h0040, 32'h0000_0004, 2'd0, 3'd0, 32'h0000_5004},
        {16'h0015, 32'h0000_0011, 2'd0, 3'd2, 32'h0}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 5, 12: return "R3";
            1, 2, 16: return "R5";
            3, 4, 11: return "R7";
            6:        return "R6";
            7, 10:    return "R8";
            8, 14:    return "R4";
            9, 15:    return "R1";
            13:       return "R10";
            default:  return "R2";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put_desc(logic ti, logic [4:0] idx, logic [31:0] base, logic [31:0] limit,
                            logic [1:0] dpl, logic [2:0] perm, logic pres);
        @(negedge clk);
        wr_en = 1'b1; wr_ti = ti; wr_idx = idx; wr_base = base; wr_limit = limit;
        wr_dpl = dpl; wr_perm = perm; wr_present = pres;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drives one request at a falling edge; result sampled at the next falling edge.
    task automatic ask(string tag, logic [15:0] sel, logic [31:0] off, logic [1:0] kind,
                       logic [2:0] exp_fault, logic [31:0] exp_lin);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_off = off; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(tag, "rsp_fault", 32'(rsp_fault), 32'(exp_fault));
        check(tag, "rsp_lin", rsp_lin, exp_lin);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_ti = 1'b0; wr_idx = '0; wr_base = '0; wr_limit = '0;
        wr_dpl = '0; wr_perm = '0; wr_present = 1'b0;
        req_valid = 1'b0; req_sel = '0; req_off = '0; req_kind = '0;
        repeat (3) @(negedge clk);
        check("R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;

        // Global table
        put_desc(1'b0, 5'd1, 32'h1000_0000, 32'h0000_FFFF, 2'd3, 3'b011, 1'b1);
        put_desc(1'b0, 5'd2, 32'hFFFF_F000, 32'hFFFF_FFFF, 2'd0, 3'b100, 1'b1);
        put_desc(1'b0, 5'd3, 32'h0000_2000, 32'h0000_00FF, 2'd3, 3'b111, 1'b0);
        put_desc(1'b0, 5'd8, 32'h0000_5000, 32'h0000_FFFF, 2'd3, 3'b111, 1'b1);
        // Local table; index 2 shares its number with a global entry (R9)
        put_desc(1'b1, 5'd1, 32'h0040_0000, 32'h0000_0FFF, 2'd2, 3'b101, 1'b1);
        put_desc(1'b1, 5'd2, 32'hABCD_0000, 32'h0000_0010, 2'd1, 3'b111, 1'b1);

        for (int i = 0; i < NV; i++) begin
            ask(tag_of(i), VEC[i][84:69], VEC[i][68:37], VEC[i][36:35], VEC[i][34:32], VEC[i][31:0]);
        end

        // R2: idle cycle after a request gives no response
        @(negedge clk);
        check("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);

        // R9: global index 2 still intact after local index 2 was written
        ask("R9", 16'h0010, 32'h0000_0010, 2'd2, 3'd0, 32'hFFFF_F010);

        // R4: clearing the present flag turns a good entry absent
        put_desc(1'b0, 5'd1, 32'h1000_0000, 32'h0000_FFFF, 2'd3, 3'b011, 1'b0);
        ask("R4", 16'h000B, 32'h0000_0010, 2'd0, 3'd1, 32'h0);

        // R10: reset forgets every entry of both tables
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        ask("R10", 16'h0010, 32'h0, 2'd2, 3'd1, 32'h0);
        ask("R10", 16'h0015, 32'h0, 2'd0, 3'd1, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule